// File: doc/BRIEF.md
# Sequential Hot-Standby Failover Switch

This block sits behind a bank of identical redundant units that all run at once. Each unit drives a data word and a failure sensor line. The switch forwards the word of exactly one unit, the active unit, to a single output. Because every spare is already running, a transfer needs no warm-up time. The new unit's data is valid in the same cycle that the selection changes.

Selection is sticky and only moves forward. After reset, unit 0 is active. The switch stays on the active unit until that unit's sensor reports a failure. It then moves to the lowest-numbered unit that has never reported a failure. Sensor reports are remembered until reset, so a unit that has failed once is never chosen again, even if its sensor later clears. When no healthy unit is left, the block raises a sticky all-failed flag and drives a fixed safe value on the output. The active index is given in binary, and a one-cycle pulse marks each transfer.

Top module: `failover_switch`

## Requirements
- R1: While reset is asserted and right after it is released, `active_idx` is 0, `switch_pulse` is 0, `all_failed` is 0 and `out_data` equals the word of unit 0.
- R2: While `all_failed` is 0, `out_data` equals bits `[i*DATA_W +: DATA_W]` of `unit_data`, where i is `active_idx`, in the same cycle with no register delay.
- R3: When the sensor bit of the active unit is high at a rising edge, then after that edge `active_idx` holds the new unit and `switch_pulse` is 1 for that one cycle. A healthy unit must remain for this to happen.
- R4: A sensor report from a unit that is not active leaves `active_idx` unchanged and produces no `switch_pulse` after that edge.
- R5: On a transfer, the new unit is the lowest index whose sensor has never been seen high since reset, so units that have already failed are skipped.
- R6: A sensor report is latched. A unit whose sensor was high at any edge since reset is never selected again, even after its sensor returns low.
- R7: `active_idx` never decreases between resets, and `switch_pulse` is 1 exactly in the cycles in which `active_idx` has just changed.
- R8: At the edge where the active unit fails and no healthy unit remains, `all_failed` rises with no `switch_pulse`. From then until reset it stays 1 and `out_data` equals `SAFE_VALUE`.
- R9: `NUM_UNITS` can range from 2 to 8. `active_idx` is a plain binary index `$clog2(NUM_UNITS)` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| unit_data | input | NUM_UNITS*DATA_W | Data words of all units, unit i at bits [i*DATA_W +: DATA_W] |
| unit_fail | input | NUM_UNITS | Failure sensor per unit, high means failed, sampled each edge |
| out_data | output | DATA_W | Word of the active unit, or SAFE_VALUE once all have failed |
| active_idx | output | IDX_W | Binary index of the active unit |
| switch_pulse | output | 1 | One-cycle pulse after each transfer to a new unit |
| all_failed | output | 1 | Sticky flag that every unit has failed |

## Verification
A lost latched failure flag shows up at the next transfer. The switch would then land on a unit that had already failed, so `active_idx` differs from the expected index one edge after the active sensor fires. A wrong selection register is visible right away on `out_data`, which the bench compares against the expected unit's word in every cycle, using fresh random data. A wrong transfer condition shows up one edge after any sensor report, either as a missing pulse or as a spurious one. The all-failed state is checked for being sticky and for driving the safe value for several cycles after it is entered.

// File: rtl/fo_pkg.sv
package fo_pkg;

  localparam int MAX_UNITS = 8;

  // Lowest index whose bit is clear; returns MAX_UNITS when all bits are set.
  function automatic logic [3:0] lowest_clear(input logic [MAX_UNITS-1:0] v);
    logic [3:0] res;
    res = 4'(MAX_UNITS);
    for (int k = MAX_UNITS - 1; k >= 0; k--) begin
      if (!v[k]) res = 4'(k);
    end
    return res;
  endfunction

endpackage

// File: rtl/fo_fail_latch.sv
module fo_fail_latch #(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] sense_i,
  output logic [NUM_UNITS-1:0] flags_q,
  output logic [NUM_UNITS-1:0] flags_eff
);

  logic [NUM_UNITS-1:0] flags_d;
  logic                 flags_en;

  // Flags seen so far plus the reports in this cycle.
  always_comb begin
    flags_eff = flags_q | sense_i;
    flags_d   = flags_eff;
    flags_en  = |sense_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  // R6: a flag that has been set stays set until reset.
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/fo_select.sv
module fo_select
  import fo_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] eff_i,
  output logic [IDX_W-1:0]     idx_q,
  output logic                 pulse_q,
  output logic                 dead_q
);

  localparam logic [3:0] UNITS4 = 4'(NUM_UNITS);

  logic [MAX_UNITS-1:0] padded;
  logic [3:0]           cand;
  logic                 active_hit;
  logic                 sel_en;
  logic [IDX_W-1:0]     idx_d;
  logic                 pulse_d;
  logic                 dead_d;

  always_comb begin
    padded                = '1;
    padded[NUM_UNITS-1:0] = eff_i;
    cand                  = lowest_clear(padded);
    active_hit            = eff_i[idx_q];
    sel_en                = !dead_q && active_hit;
    idx_d                 = idx_q;
    pulse_d               = 1'b0;
    dead_d                = dead_q;
    if (sel_en) begin
      if (cand < UNITS4) begin
        idx_d   = cand[IDX_W-1:0];
        pulse_d = 1'b1;
      end else begin
        dead_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      dead_q <= 1'b0;
    end else if (sel_en) begin
      idx_q  <= idx_d;
      dead_q <= dead_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  // R7: the index only moves upward between resets.
  p_idx_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (idx_q >= $past(idx_q)));

  // R7: the pulse marks exactly the cycles following an index change.
  p_pulse_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pulse_q == (idx_q != $past(idx_q))));

  // R8: the all-failed state is sticky.
  p_dead_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |=> dead_q);

endmodule

// File: rtl/fo_outmux.sv
module fo_outmux #(
  parameter int                NUM_UNITS  = 4,
  parameter int                DATA_W     = 16,
  parameter int                IDX_W      = 2,
  parameter logic [DATA_W-1:0] SAFE_VALUE = '1
) (
  input  logic [NUM_UNITS*DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]            sel_i,
  input  logic                        dead_i,
  output logic [DATA_W-1:0]           data_o
);

  logic [DATA_W-1:0] lanes [NUM_UNITS];

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_lane
    assign lanes[g] = data_i[g*DATA_W +: DATA_W];
  end

  always_comb begin
    data_o = SAFE_VALUE;
    if (!dead_i) begin
      for (int k = 0; k < NUM_UNITS; k++) begin
        if (sel_i == IDX_W'(k)) data_o = lanes[k];
      end
    end
  end

endmodule

// File: rtl/failover_switch.sv
module failover_switch #(
  parameter int                NUM_UNITS  = 4,
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] SAFE_VALUE = '1,
  localparam int               IDX_W      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_UNITS*DATA_W-1:0] unit_data,
  input  logic [NUM_UNITS-1:0]        unit_fail,
  output logic [DATA_W-1:0]           out_data,
  output logic [IDX_W-1:0]            active_idx,
  output logic                        switch_pulse,
  output logic                        all_failed
);

  logic [NUM_UNITS-1:0] fail_flags;
  logic [NUM_UNITS-1:0] fail_eff;

  fo_fail_latch #(.NUM_UNITS(NUM_UNITS)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sense_i   (unit_fail),
    .flags_q   (fail_flags),
    .flags_eff (fail_eff)
  );

  fo_select #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .eff_i   (fail_eff),
    .idx_q   (active_idx),
    .pulse_q (switch_pulse),
    .dead_q  (all_failed)
  );

  fo_outmux #(
    .NUM_UNITS (NUM_UNITS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .SAFE_VALUE(SAFE_VALUE)
  ) u_mux (
    .data_i (unit_data),
    .sel_i  (active_idx),
    .dead_i (all_failed),
    .data_o (out_data)
  );

  // R5/R6: a unit that has just been switched in has no latched failure.
  p_pick_healthy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> !fail_flags[active_idx]);

  // R4: with no report on the active unit, no transfer follows.
  p_nonactive_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_eff[active_idx] |=> !switch_pulse);

  // R8: the all-failed flag implies every unit has a latched failure.
  p_dead_all_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    all_failed |-> (&fail_flags));

  // R9: the index stays inside the unit range.
  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (int'(active_idx) < NUM_UNITS));

endmodule

// File: tb/sim_failover_switch.sv
`timescale 1ns/1ps
module sim_failover_switch;

  localparam int          N    = 4;
  localparam int          W    = 16;
  localparam int          IW   = 2;
  localparam logic [W-1:0] SAFE = 16'h5A5A;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N*W-1:0] unit_data;
  logic [N-1:0]   unit_fail;
  logic [W-1:0]   out_data;
  logic [IW-1:0]  active_idx;
  logic           switch_pulse;
  logic           all_failed;

  always #10 clk = ~clk;

  failover_switch #(.NUM_UNITS(N), .DATA_W(W), .SAFE_VALUE(SAFE)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .unit_data    (unit_data),
    .unit_fail    (unit_fail),
    .out_data     (out_data),
    .active_idx   (active_idx),
    .switch_pulse (switch_pulse),
    .all_failed   (all_failed)
  );

  int       checks = 0;
  int       errors = 0;
  bit       done   = 1'b0;
  logic [N-1:0] m_lat;
  int       m_idx;
  bit       m_dead;
  bit       m_pulse;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane(input int i);
    return unit_data[i*W +: W];
  endfunction

  function automatic int first_healthy(input logic [N-1:0] flags);
    int r = -1;
    for (int k = N - 1; k >= 0; k--) if (!flags[k]) r = k;
    return r;
  endfunction

  task automatic fresh_data();
    for (int k = 0; k < N; k++) unit_data[k*W +: W] = W'($urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    unit_fail = '0;
    fresh_data();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_lat = '0; m_idx = 0; m_dead = 1'b0; m_pulse = 1'b0;
    #1;
    check("R1 idx", 32'(active_idx), 32'd0);
    check("R1 pulse", 32'(switch_pulse), 32'd0);
    check("R1 dead", 32'(all_failed), 32'd0);
    check("R1 out", 32'(out_data), 32'(lane(0)));
  endtask

  // Called at a negedge: apply sensors, check output mux, clock, check state.
  task automatic step(input logic [N-1:0] f, input string tag);
    logic [N-1:0] eff;
    int prev, nxt;
    unit_fail = f;
    fresh_data();
    #1;
    if (m_dead) check("R8 safe out", 32'(out_data), 32'(SAFE));
    else        check("R2 out", 32'(out_data), 32'(lane(m_idx)));
    @(posedge clk);
    eff = m_lat | f;
    prev = m_idx;
    m_pulse = 1'b0;
    if (!m_dead && eff[m_idx]) begin
      nxt = first_healthy(eff);
      if (nxt >= 0) begin m_idx = nxt; m_pulse = 1'b1; end
      else m_dead = 1'b1;
    end
    m_lat = eff;
    @(negedge clk);
    check({tag, " idx"}, 32'(active_idx), 32'(m_idx));
    check({tag, " pulse"}, 32'(switch_pulse), 32'(m_pulse));
    check({tag, " dead"}, 32'(all_failed), 32'(m_dead));
    check("R7 monotonic", 32'(int'(active_idx) >= prev), 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] f;
    void'($urandom(32'd777));
    rst_n = 1'b0;
    unit_fail = '0;
    unit_data = '0;
    do_reset();

    // Directed: non-active failure, transfer, skip, single pulse, exhaustion.
    step(4'b0000, "R2");
    step(4'b0100, "R4");
    step(4'b0000, "R4");
    step(4'b0001, "R3");
    step(4'b0000, "R3");
    step(4'b0010, "R5");
    step(4'b0000, "R7");
    step(4'b1000, "R8");
    step(4'b0000, "R8");
    step(4'b1111, "R8");
    step(4'b0000, "R8");

    // R6: transient report on unit 1, then unit 0 fails; unit 2 expected.
    do_reset();
    step(4'b0010, "R6");
    step(4'b0000, "R6");
    step(4'b0000, "R6");
    step(4'b0001, "R6");
    check("R6 skip cleared unit", 32'(active_idx), 32'd2);

    // R3: report on unit 0 already present when reset releases.
    do_reset();
    step(4'b0001, "R3");
    check("R3 first transfer", 32'(active_idx), 32'd1);

    // R9/R5: simultaneous reports on active and next units.
    step(4'b0110, "R5");
    check("R9 idx three", 32'(active_idx), 32'd3);

    // Random phase.
    for (int r = 0; r < 30; r++) begin
      do_reset();
      for (int s = 0; s < 40; s++) begin
        f = '0;
        for (int k = 0; k < N; k++) if (($urandom % 12) == 0) f[k] = 1'b1;
        step(f, "R3");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule